// File: doc/BRIEF.md
# Unsigned Compare-to-Condition-Field Unit

This execution unit serves a 64-bit RISC core. Each cycle it may receive one 32-bit instruction word, the two source operand values already read from the register file, and the current sticky-overflow bit from the fixed-point status register. It recognises the unsigned register-compare instruction and compares the two operands as unsigned magnitudes. The compare covers either the low 32 bits of each operand or all 64 bits, as the length bit in the word selects.

The outcome is a 4-bit field: less-than, greater-than, equal, and a copy of the sticky-overflow bit. The unit writes this field into one of eight slots of a 32-bit condition register that it holds itself. For every presented word it reports at once, without a clock, whether the word is a legal instance of the instruction or an illegal one. It writes no other state.

Top module: `ucmp_cr_unit`

## Requirements
- R1: With `in_valid` high, `legal_o` is 1 in the same cycle exactly when instruction bits 0–5 (big-endian, `insn[31:26]`) equal 31, bits 21–30 (`insn[10:1]`) equal 32, and bit 9 (`insn[22]`) and bit 31 (`insn[0]`) are both 0. `legal_o` and `illegal_o` are never 1 together.
- R2: With `in_valid` high and the condition of R1 not met, `illegal_o` is 1 in that cycle, and `cr_o` is unchanged after the next edge. This includes a set bit 9 or bit 31, a wrong primary opcode and a wrong extended opcode.
- R3: With `in_valid` low, `legal_o` and `illegal_o` are 0 and `cr_o` does not change, even when a legal word is on `insn`.
- R4: When length bit 10 (`insn[21]`) is 0, only operand bits [31:0] take part in the compare. Bits [63:32] of both operands have no effect.
- R5: When `insn[21]` is 1, all 64 operand bits are compared.
- R6: Operands are unsigned in both modes, with no sign extension. For example, 0x80000000 is greater than 1 in 32-bit mode.
- R7: The written field holds, from its most significant bit to its least, LT, GT, EQ and SO. Exactly one of LT, GT and EQ is 1.
- R8: The SO bit of the written field equals `so_in` at the clock edge of the write.
- R9: The field index is instruction bits 6–8 (`insn[25:23]`). Field n occupies `cr_o[31-4n:28-4n]`, so field 0 is the top nibble. The other seven fields are unchanged.
- R10: A later legal compare to the same field fully replaces the earlier value.
- R11: Synchronous reset (`rst` high at a rising edge) clears `cr_o` to zero.
- R12: The source-select fields (`insn[20:11]`) have no effect on legality or on the result.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| opa | input | 64 | First source operand value |
| opb | input | 64 | Second source operand value |
| so_in | input | 1 | Sticky-overflow bit from the status register |
| legal_o | output | 1 | Presented word is a legal unsigned register compare |
| illegal_o | output | 1 | Presented word is not a legal instance |
| cr_o | output | 32 | Condition register, eight 4-bit fields |

## Verification
On every cycle, the bound checker enforces the following. A legal word leaves exactly one relation bit set in its target field and copies `so_in` into that field's SO bit. It leaves the other seven fields untouched. Illegal and idle cycles leave the register frozen, and equal operands yield EQ in the selected width. What only the bench scenarios can show is whether the relation is the right one. This covers ignoring the upper halves in 32-bit mode, unsigned ordering across the sign bit, overwrite of a reused field, every field slot, and the reset value.

// File: rtl/ucmp_pkg.sv
package ucmp_pkg;
   localparam int unsigned PRIMARY_OP = 31;
   localparam int unsigned EXT_OP     = 32;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } crf_t;
endpackage

// File: rtl/ucmp_decode.sv
module ucmp_decode #(
   parameter int IW   = 32,
   parameter int FLDW = 3
) (
   input  logic [IW-1:0]   insn,
   input  logic            valid,
   output logic            legal,
   output logic            illegal,
   output logic [FLDW-1:0] fld,
   output logic            wide
);
   // big-endian bit k lives at little-endian index IW-1-k
   localparam int POP_HI   = IW - 1;
   localparam int POP_LO   = IW - 6;
   localparam int FLD_HI   = IW - 7;
   localparam int FLD_LO   = IW - 6 - FLDW;
   localparam int RSV_BIT  = IW - 10;
   localparam int WIDE_BIT = IW - 11;
   localparam int XO_HI    = IW - 22;
   localparam int XO_LO    = IW - 31;
   localparam int RC_BIT   = 0;

   generate
      if (IW != 32) begin : g_bad_iw
         $error("ucmp_decode: instruction width must be 32");
      end
      if (FLDW != 3) begin : g_bad_fldw
         $error("ucmp_decode: field index must be 3 bits");
      end
   endgenerate

   logic op_match;
   logic rsv_clean;

   always_comb begin
      op_match  = (insn[POP_HI:POP_LO] == 6'(ucmp_pkg::PRIMARY_OP)) &&
                  (insn[XO_HI:XO_LO]   == 10'(ucmp_pkg::EXT_OP));
      rsv_clean = !insn[RSV_BIT] && !insn[RC_BIT];
      legal     = valid && op_match && rsv_clean;
      illegal   = valid && !(op_match && rsv_clean);
      fld       = insn[FLD_HI:FLD_LO];
      wide      = insn[WIDE_BIT];
   end
endmodule

// File: rtl/ucmp_magcmp.sv
module ucmp_magcmp #(
   parameter int XLEN  = 64,
   parameter int STYLE = 0   // 0: narrow-then-compare, 1: split halves
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            wide,
   output logic            lt,
   output logic            gt,
   output logic            eq
);
   localparam int HALF = XLEN / 2;

   generate
      if (XLEN % 2 != 0 || XLEN < 2) begin : g_bad_xlen
         $error("ucmp_magcmp: XLEN must be even and at least 2");
      end
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("ucmp_magcmp: STYLE must be 0 or 1");
      end

      if (STYLE == 0) begin : g_narrow
         logic [XLEN-1:0] xa, xb;
         always_comb begin
            xa = wide ? a : {{HALF{1'b0}}, a[HALF-1:0]};
            xb = wide ? b : {{HALF{1'b0}}, b[HALF-1:0]};
            lt = xa < xb;
            gt = xa > xb;
            eq = xa == xb;
         end
      end else begin : g_split
         logic hi_lt, hi_eq, lo_lt, lo_eq;
         always_comb begin
            hi_lt = a[XLEN-1:HALF] < b[XLEN-1:HALF];
            hi_eq = a[XLEN-1:HALF] == b[XLEN-1:HALF];
            lo_lt = a[HALF-1:0] < b[HALF-1:0];
            lo_eq = a[HALF-1:0] == b[HALF-1:0];
            if (wide) begin
               lt = hi_lt || (hi_eq && lo_lt);
               eq = hi_eq && lo_eq;
            end else begin
               lt = lo_lt;
               eq = lo_eq;
            end
            gt = !lt && !eq;
         end
      end
   endgenerate
endmodule

// File: rtl/ucmp_crfile.sv
module ucmp_crfile #(
   parameter int NFIELD = 8,
   parameter int FW     = 4,
   parameter int FLDW   = $clog2(NFIELD)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we,
   input  logic [FLDW-1:0]      fld,
   input  logic [FW-1:0]        nib,
   output logic [NFIELD*FW-1:0] cr
);
   generate
      if (NFIELD < 2 || (1 << FLDW) != NFIELD) begin : g_bad_n
         $error("ucmp_crfile: NFIELD must be a power of two of at least 2");
      end
      for (genvar n = 0; n < NFIELD; n++) begin : g_fld
         logic [FW-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && fld == FLDW'(n))
               q <= nib;
         end
         // field 0 is the most significant slot
         assign cr[(NFIELD-1-n)*FW +: FW] = q;
      end
   endgenerate
endmodule

// File: rtl/ucmp_cr_unit.sv
module ucmp_cr_unit #(
   parameter int XLEN      = 64,
   parameter int NFIELD    = 8,
   parameter int CMP_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [31:0]         insn,
   input  logic [XLEN-1:0]     opa,
   input  logic [XLEN-1:0]     opb,
   input  logic                so_in,
   output logic                legal_o,
   output logic                illegal_o,
   output logic [NFIELD*4-1:0] cr_o
);
   localparam int FW   = $bits(ucmp_pkg::crf_t);
   localparam int FLDW = $clog2(NFIELD);

   generate
      if (NFIELD != 8) begin : g_bad_nfield
         $error("ucmp_cr_unit: the encoding addresses exactly eight fields");
      end
      if (XLEN != 64) begin : g_bad_xlen
         $error("ucmp_cr_unit: operands must be 64 bits");
      end
   endgenerate

   logic [FLDW-1:0] fld;
   logic            wide;
   logic            lt, gt, eq;
   ucmp_pkg::crf_t  res;

   ucmp_decode #(.IW(32), .FLDW(FLDW)) u_dec (
      .insn    (insn),
      .valid   (in_valid),
      .legal   (legal_o),
      .illegal (illegal_o),
      .fld     (fld),
      .wide    (wide)
   );

   ucmp_magcmp #(.XLEN(XLEN), .STYLE(CMP_STYLE)) u_cmp (
      .a    (opa),
      .b    (opb),
      .wide (wide),
      .lt   (lt),
      .gt   (gt),
      .eq   (eq)
   );

   always_comb begin
      res.lt = lt;
      res.gt = gt;
      res.eq = eq;
      res.so = so_in;
   end

   ucmp_crfile #(.NFIELD(NFIELD), .FW(FW), .FLDW(FLDW)) u_cr (
      .clk (clk),
      .rst (rst),
      .we  (legal_o),
      .fld (fld),
      .nib (res),
      .cr  (cr_o)
   );
endmodule

// File: rtl/ucmp_cr_unit_chk.sv
module ucmp_cr_unit_chk #(
   parameter int XLEN   = 64,
   parameter int NFIELD = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [31:0]         insn,
   input logic [XLEN-1:0]     opa,
   input logic [XLEN-1:0]     opb,
   input logic                so_in,
   input logic                legal_o,
   input logic                illegal_o,
   input logic [NFIELD*4-1:0] cr_o
);
   localparam int CRW = NFIELD * 4;

   logic [2:0]     fld_q;
   logic [3:0]     nib_now;
   logic [CRW-1:0] mask_q;

   always_ff @(posedge clk) fld_q <= insn[25:23];

   always_comb begin
      nib_now = cr_o[(NFIELD-1-int'(fld_q))*4 +: 4];
      mask_q  = CRW'(4'hF) << ((NFIELD-1-int'(fld_q))*4);
   end

   assert_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
      !(legal_o && illegal_o));

   assert_illegal_hold_R2: assert property (@(posedge clk) disable iff (rst)
      illegal_o |=> $stable(cr_o));

   assert_idle_flags_R3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> (!legal_o && !illegal_o));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(cr_o));

   assert_low_equal_R4: assert property (@(posedge clk) disable iff (rst)
      (legal_o && !insn[21] && opa[31:0] == opb[31:0]) |=> nib_now[1]);

   assert_full_equal_R5: assert property (@(posedge clk) disable iff (rst)
      (legal_o && insn[21] && opa == opb) |=> nib_now[1]);

   assert_one_relation_R7: assert property (@(posedge clk) disable iff (rst)
      legal_o |=> $onehot(nib_now[3:1]));

   assert_so_copy_R8: assert property (@(posedge clk) disable iff (rst)
      legal_o |=> (nib_now[0] == $past(so_in)));

   assert_others_kept_R9: assert property (@(posedge clk) disable iff (rst)
      legal_o |=> (((cr_o ^ $past(cr_o)) & ~mask_q) == '0));
endmodule

bind ucmp_cr_unit ucmp_cr_unit_chk #(.XLEN(XLEN), .NFIELD(NFIELD)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .insn      (insn),
   .opa       (opa),
   .opb       (opb),
   .so_in     (so_in),
   .legal_o   (legal_o),
   .illegal_o (illegal_o),
   .cr_o      (cr_o)
);

// File: tb/ucmp_cr_unit_test.sv
module ucmp_cr_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        so_in = 1'b0;
   logic        legal_o, illegal_o;
   logic [31:0] cr_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] mdl = '0;

   always #4 clk = ~clk;   // 125 MHz

   ucmp_cr_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .opa(opa), .opb(opb), .so_in(so_in),
      .legal_o(legal_o), .illegal_o(illegal_o), .cr_o(cr_o)
   );

   // {field, L, a, b, so, expected nibble LT GT EQ SO}
   localparam int NV = 10;
   localparam logic [136:0] VEC [NV] = '{
      {3'd0, 1'b1, 64'd5, 64'd3, 1'b0, 4'b0100},
      {3'd1, 1'b1, 64'd3, 64'd5, 1'b1, 4'b1001},
      {3'd2, 1'b1, 64'hDEAD, 64'hDEAD, 1'b0, 4'b0010},
      {3'd3, 1'b0, 64'hFFFFFFFF_00000001, 64'h00000000_00000002, 1'b0, 4'b1000},
      {3'd4, 1'b1, 64'hFFFFFFFF_00000001, 64'h00000000_00000002, 1'b0, 4'b0100},
      {3'd5, 1'b0, 64'h00000000_80000000, 64'd1, 1'b0, 4'b0100},
      {3'd6, 1'b1, 64'h80000000_00000000, 64'h7FFFFFFF_FFFFFFFF, 1'b0, 4'b0100},
      {3'd7, 1'b0, 64'h12345678_AAAAAAAA, 64'h87654321_AAAAAAAA, 1'b1, 4'b0011},
      {3'd7, 1'b1, 64'd0, 64'hFFFFFFFF_FFFFFFFF, 1'b0, 4'b1000},
      {3'd0, 1'b0, 64'h00000000_FFFFFFFF, 64'h00000000_FFFFFFFE, 1'b1, 4'b0101}
   };

   function automatic logic [31:0] mk(input logic [2:0] f, input logic l);
      return 32'h7C000040 | (32'(f) << 23) | (32'(l) << 21);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Present one word; flags checked in-cycle, register after the next edge.
   task automatic run_op(input string tag, input logic [31:0] w, input logic [63:0] a,
                         input logic [63:0] b, input logic s, input logic v,
                         input logic exp_legal, input logic [3:0] exp_nib);
      @(negedge clk);
      insn = w; opa = a; opb = b; so_in = s; in_valid = v;
      #1;
      check({tag, " legal_o"}, 64'(legal_o), 64'(exp_legal));
      check({tag, " illegal_o"}, 64'(illegal_o), 64'(v && !exp_legal));
      if (exp_legal) mdl[31 - 4*int'(w[25:23]) -: 4] = exp_nib;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " cr_o"}, 64'(cr_o), 64'(mdl));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [2:0]  f;
      logic        l, s;
      logic [63:0] a, b;
      logic [3:0]  nb;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check("R11 reset value", 64'(cr_o), 64'd0);

      for (int i = 0; i < NV; i++) begin
         {f, l, a, b, s, nb} = VEC[i];
         run_op("vector R4 R5 R6 R7 R8 R9 R10", mk(f, l), a, b, s, 1'b1, 1'b1, nb);
      end

      run_op("R2 bit9 set", mk(3'd2, 1'b1) | 32'h0040_0000, 64'd1, 64'd2, 1'b0, 1'b1, 1'b0, 4'b0);
      run_op("R2 bit31 set", mk(3'd3, 1'b0) | 32'h1, 64'd1, 64'd2, 1'b0, 1'b1, 1'b0, 4'b0);
      run_op("R2 primary opcode", mk(3'd4, 1'b1) ^ 32'h0400_0000, 64'd1, 64'd2, 1'b0, 1'b1, 1'b0, 4'b0);
      run_op("R2 extended opcode", mk(3'd5, 1'b1) | 32'h2, 64'd1, 64'd2, 1'b0, 1'b1, 1'b0, 4'b0);
      run_op("R3 valid low", mk(3'd6, 1'b1), 64'd1, 64'd2, 1'b1, 1'b0, 1'b0, 4'b0);
      run_op("R12 source fields R1", mk(3'd4, 1'b1) | 32'h001F_F800, 64'd9, 64'd9, 1'b0, 1'b1, 1'b1, 4'b0010);
      run_op("R6 low half sign bit", mk(3'd1, 1'b0), 64'd1, 64'h00000000_80000000, 1'b0, 1'b1, 1'b1, 4'b1000);

      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      mdl = '0;
      check("R11 reset after writes", 64'(cr_o), 64'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule